// File: doc/BRIEF.md
# Path Signal Label Monitor

This block watches the path signal label byte that arrives once per frame. It raises and clears two alarms. The mismatch alarm reports a label that is not the expected one. The unequipped alarm reports a label of all zeros, which means the path carries no payload. Each label enters as one item on a valid/ready stream, and one accepted item counts as one frame. A label is taken as expected when it equals a programmed value. It is also taken as expected when it equals the fixed equipped code 01H, unless a control input turns that second comparison off.

Both alarms are filtered by persistence. An alarm changes state only after five frames in a row disagree with its present state. A single frame that agrees with the present state starts the count again. The unequipped condition takes priority, so the mismatch output stays low while the unequipped alarm is set. The most recent accepted label is held on a status output.

Back-pressure: `lbl_ready` is low during reset and on the first cycle after it, and high from then on. A label is accepted on a rising clock edge where `lbl_valid` and `lbl_ready` are both high. The source may hold `lbl_valid` high for consecutive frames, and each cycle with both signals high counts as one frame. A cycle without acceptance changes no state.

Top module: `label_monitor`

## Requirements
- R1: An accepted label counts as matching if it equals `exp_label`, or if it equals 8'h01 while `fixed_cmp_off` is 0.
- R2: While `fixed_cmp_off` is 1, 8'h01 counts as matching only when `exp_label` is 8'h01.
- R3: The internal mismatch state sets after 5 consecutive accepted non-matching labels. `mismatch_alarm` shows it on the cycle after the fifth acceptance, unless R6 applies.
- R4: The mismatch state clears after 5 consecutive accepted matching labels, visible on the cycle after the fifth acceptance.
- R5: `unequip_alarm` sets after 5 consecutive accepted labels equal to 8'h00. It clears after 5 consecutive accepted non-zero labels. Both changes are visible on the cycle after the fifth acceptance.
- R6: While `unequip_alarm` is 1, `mismatch_alarm` is 0. The internal mismatch state keeps running, so it can appear on the output as soon as the unequipped alarm clears.
- R7: An accepted label that agrees with an alarm's present state resets that alarm's persistence count to zero.
- R8: Reset clears both alarms, both counts and `last_label`, and holds `lbl_ready` at 0. Cycles without an acceptance change no output.
- R9: `last_label` equals the most recently accepted label, from the cycle after its acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lbl_valid | input | 1 | Label item present |
| lbl_ready | output | 1 | Block can accept a label |
| lbl_data | input | 8 | Received label byte |
| exp_label | input | 8 | Programmed expected label |
| fixed_cmp_off | input | 1 | 1 turns off acceptance of the fixed 01H code |
| mismatch_alarm | output | 1 | Label mismatch alarm, after suppression |
| unequip_alarm | output | 1 | All-zero label alarm |
| last_label | output | 8 | Most recent accepted label |

## Verification
The hardest situation to reach is the mismatch state becoming visible at the moment the unequipped alarm clears. A run of zero labels sets the unequipped alarm and the hidden mismatch state together. The stimulus then sends non-zero labels that still do not match. On the fifth of them the unequipped alarm clears and `mismatch_alarm` goes high on the same cycle. The stimulus also cuts a mismatch run short at four frames to show the count starting again (R7), and it switches `fixed_cmp_off` partway through so that 01H stops matching.

// File: rtl/label_mon_pkg.sv
package label_mon_pkg;
  parameter int unsigned LABEL_W        = 8;
  parameter int unsigned PERSIST_FRAMES = 5;
  parameter logic [7:0]  EQUIPPED_CODE  = 8'h01;

  // index of each persistence filter in the filter bank
  typedef enum logic [0:0] {
    ALM_MISMATCH = 1'b0,
    ALM_UNEQUIP  = 1'b1
  } alarm_idx_e;

  localparam int unsigned NUM_ALARMS = 2;
endpackage

// File: rtl/label_classify.sv
module label_classify
  import label_mon_pkg::*;
#(
  parameter int unsigned W = LABEL_W
) (
  input  logic [W-1:0] label,
  input  logic [W-1:0] expected,
  input  logic         fixed_off,
  output logic         is_match,
  output logic         is_zero
);
  logic hit_prog;
  logic hit_fixed;

  always_comb begin
    hit_prog  = (label == expected);
    hit_fixed = !fixed_off && (label == W'(EQUIPPED_CODE));
    is_match  = hit_prog || hit_fixed;
    is_zero   = (label == '0);
  end
endmodule

// File: rtl/label_persist.sv
module label_persist #(
  parameter int unsigned N  = 5,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic cond,
  output logic alarm
);
  logic [CW-1:0] run;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= '0;
      alarm <= 1'b0;
    end else if (strobe) begin
      if (cond != alarm) begin
        if (run == LAST) begin
          alarm <= cond;
          run   <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/label_monitor.sv
module label_monitor
  import label_mon_pkg::*;
#(
  parameter int unsigned W       = LABEL_W,
  parameter int unsigned PERSIST = PERSIST_FRAMES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lbl_valid,
  output logic         lbl_ready,
  input  logic [W-1:0] lbl_data,
  input  logic [W-1:0] exp_label,
  input  logic         fixed_cmp_off,
  output logic         mismatch_alarm,
  output logic         unequip_alarm,
  output logic [W-1:0] last_label
);
  localparam int unsigned CW = $clog2(PERSIST + 1);

  logic ready_q;
  logic accept;
  logic is_match;
  logic is_zero;
  logic [NUM_ALARMS-1:0] cond_vec;
  logic [NUM_ALARMS-1:0] alarm_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign lbl_ready = ready_q;
  assign accept    = lbl_valid && ready_q;

  label_classify #(.W(W)) u_cls (
    .label    (lbl_data),
    .expected (exp_label),
    .fixed_off(fixed_cmp_off),
    .is_match (is_match),
    .is_zero  (is_zero)
  );

  assign cond_vec[ALM_MISMATCH] = !is_match;
  assign cond_vec[ALM_UNEQUIP]  = is_zero;

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_filt
    label_persist #(.N(PERSIST), .CW(CW)) u_pf (
      .clk   (clk),
      .rst_n (rst_n),
      .strobe(accept),
      .cond  (cond_vec[g]),
      .alarm (alarm_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      last_label <= '0;
    else if (accept) last_label <= lbl_data;
  end

  assign unequip_alarm  = alarm_vec[ALM_UNEQUIP];
  assign mismatch_alarm = alarm_vec[ALM_MISMATCH] && !alarm_vec[ALM_UNEQUIP];
endmodule

// File: rtl/label_monitor_chk.sv
module label_monitor_chk #(
  parameter int unsigned W       = 8,
  parameter int unsigned PERSIST = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lbl_valid,
  input logic         lbl_ready,
  input logic [W-1:0] lbl_data,
  input logic         mismatch_alarm,
  input logic         unequip_alarm,
  input logic [W-1:0] last_label
);
  logic acc;
  logic [7:0] zrun;
  logic [7:0] nzrun;

  assign acc = lbl_valid && lbl_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zrun  <= '0;
      nzrun <= '0;
    end else if (acc) begin
      if (lbl_data == '0) begin
        nzrun <= '0;
        if (zrun != 8'hFF) zrun <= zrun + 1'b1;
      end else begin
        zrun <= '0;
        if (nzrun != 8'hFF) nzrun <= nzrun + 1'b1;
      end
    end
  end

  // R6
  alarm_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mismatch_alarm && unequip_alarm));

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(unequip_alarm) && $stable(mismatch_alarm) && $stable(last_label)));

  // R5
  unequip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unequip_alarm) |-> (zrun >= 8'(PERSIST)));

  // R5
  unequip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unequip_alarm) |-> (nzrun >= 8'(PERSIST)));

  // R9
  last_label_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (last_label == $past(lbl_data)));
endmodule

bind label_monitor label_monitor_chk #(.W(W), .PERSIST(PERSIST)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lbl_valid     (lbl_valid),
  .lbl_ready     (lbl_ready),
  .lbl_data      (lbl_data),
  .mismatch_alarm(mismatch_alarm),
  .unequip_alarm (unequip_alarm),
  .last_label    (last_label)
);

// File: tb/tb_label_monitor.sv
`timescale 1ns/1ps
module tb_label_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lbl_valid = 1'b0;
  logic       lbl_ready;
  logic [7:0] lbl_data = '0;
  logic [7:0] exp_label = 8'h3C;
  logic       fixed_cmp_off = 1'b0;
  logic       mismatch_alarm;
  logic       unequip_alarm;
  logic [7:0] last_label;

  always #5 clk = ~clk;

  label_monitor dut (
    .clk(clk), .rst_n(rst_n), .lbl_valid(lbl_valid), .lbl_ready(lbl_ready),
    .lbl_data(lbl_data), .exp_label(exp_label), .fixed_cmp_off(fixed_cmp_off),
    .mismatch_alarm(mismatch_alarm), .unequip_alarm(unequip_alarm),
    .last_label(last_label)
  );

  typedef struct {
    logic       mm;
    logic       ue;
    logic [7:0] last;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int  bad_run = 0, good_run = 0, zero_run = 0, nz_run = 0;
  bit  m_mm = 0, m_ue = 0;

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic model(input logic [7:0] lab, output exp_t e);
    bit match;
    match = (lab == exp_label) || (!fixed_cmp_off && lab == 8'h01);
    if (match) begin bad_run = 0; good_run++; if (good_run >= 5) m_mm = 0; end
    else       begin good_run = 0; bad_run++; if (bad_run >= 5) m_mm = 1; end
    if (lab == 8'h00) begin nz_run = 0; zero_run++; if (zero_run >= 5) m_ue = 1; end
    else              begin zero_run = 0; nz_run++; if (nz_run >= 5) m_ue = 0; end
    e.mm = m_mm && !m_ue;
    e.ue = m_ue;
    e.last = lab;
  endtask

  task automatic send(input logic [7:0] lab, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      model(lab, e);
      e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      lbl_valid = 1'b1;
      lbl_data  = lab;
      @(negedge clk);
      lbl_valid = 1'b0;
    end
  endtask

  // monitor: compare after each acceptance
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && lbl_valid && lbl_ready) begin
        exp_t e;
        @(negedge clk);
        e = exp_q.pop_front();
        check({e.tag, " mismatch"}, mismatch_alarm, e.mm);
        check({e.tag, " unequip"},  unequip_alarm,  e.ue);
        check({"R9 last_label"},    last_label,     e.last);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset mismatch", mismatch_alarm, 0);
    check("R8 reset unequip", unequip_alarm, 0);
    check("R8 reset last_label", last_label, 0);
    check("R8 ready low in reset", lbl_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 ready after reset", lbl_ready, 1);

    send(8'h3C, 3, "R1 programmed");
    send(8'h01, 2, "R1 fixed code");
    send(8'h55, 4, "R7 short run");
    send(8'h3C, 1, "R7 run broken");
    send(8'h55, 4, "R7 restarted");
    check("R7 no alarm after 4", mismatch_alarm, 0);
    send(8'h55, 1, "R3 fifth bad");
    check("R3 mismatch set", mismatch_alarm, 1);
    send(8'h01, 5, "R4 clear");
    check("R4 mismatch cleared", mismatch_alarm, 0);
    fixed_cmp_off = 1'b1;
    send(8'h01, 5, "R2 fixed off");
    check("R2 mismatch from 01", mismatch_alarm, 1);
    send(8'h3C, 5, "R4 clear prog");
    send(8'h00, 5, "R5 zero set");
    check("R5 unequip set", unequip_alarm, 1);
    check("R6 mismatch suppressed", mismatch_alarm, 0);
    send(8'h00, 2, "R6 hold");
    // idle cycles: nothing may move
    repeat (6) @(negedge clk);
    check("R8 idle unequip", unequip_alarm, 1);
    check("R8 idle last_label", last_label, 8'h00);
    send(8'h77, 5, "R6 reveal");
    check("R5 unequip cleared", unequip_alarm, 0);
    check("R6 mismatch visible", mismatch_alarm, 1);
    send(8'h3C, 5, "R4 final clear");
    repeat (3) @(negedge clk);
    check("R4 final", mismatch_alarm, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule